// File: doc/BRIEF.md
# Sequential Integer Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division over many clock cycles and leaves its result in two dedicated result registers, HI and LO, which sit apart from any general register file. A single-cycle start strobe carries a two-bit opcode and two operands. The unit then iterates one bit per cycle and pulses `done` when the result has been committed. Both result registers are always visible on output ports, which stand in for the move-from-HI and move-from-LO operations.

A multiply leaves the upper half of the 64-bit product in HI and the lower half in LO. A divide leaves the remainder in HI and the quotient in LO, so that dividend = quotient × divisor + remainder. Signed and unsigned forms exist for both operations. No overflow is ever flagged. Software that needs to detect multiply overflow has to inspect HI itself. Division by zero completes normally, with fixed result values.

Internally, the operands are reduced to magnitudes when the start strobe is accepted. Then 32 shift-add or restoring-subtract iterations run. A final cycle applies the result signs and writes HI and LO.

Top module: `muldiv_unit`

## Requirements
- R1: With `startOp` = 1 (unsigned multiply), HI holds bits 63..32 and LO holds bits 31..0 of the unsigned 64-bit product of `opA` and `opB`.
- R2: With `startOp` = 0 (signed multiply), HI:LO holds the two's complement 64-bit product of `opA` and `opB`. No overflow indication exists.
- R3: With `startOp` = 3 (unsigned divide) and a nonzero divisor, LO holds `opA / opB` and HI holds `opA % opB`, both taken as unsigned values.
- R4: With `startOp` = 2 (signed divide) and a nonzero divisor, the quotient in LO is truncated toward zero. The remainder in HI has the sign of the dividend. The case 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0, with no error indication.
- R5: A divide by zero, signed or unsigned, leaves LO = 0xFFFFFFFF and HI equal to `opA`.
- R6: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse that appears 33 rising edges after the edge that sampled the start. `busy` is low whenever `done` is high.
- R7: A start strobe sampled while `busy` is high is ignored. The running operation's result is unchanged and no extra `done` pulse is produced.
- R8: HI and LO keep their previous contents while an operation runs. They change only in the cycle in which `done` rises.
- R9: After reset, `busy` = 0, `done` = 0, and HI = LO = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start strobe, sampled when the unit is idle |
| startOp | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| opA | input | 32 | Multiplicand or dividend |
| opB | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when HI/LO are written |
| hiOut | output | 32 | HI register: product upper half or remainder |
| loOut | output | 32 | LO register: product lower half or quotient |

## Verification
The bench targets these corner cases:
- **Sign handling:** operand pairs with mixed signs and with the most negative value. A design that negated the remainder by the quotient's sign, or rounded the quotient toward minus infinity, gives the wrong HI for a negative dividend.
- **Division by zero and overflow:** both divide-by-zero forms and the 0x80000000 / −1 overflow case. A design that corrected the sign of the all-ones quotient would report 1 instead.
- **Busy window:** a second start issued mid-operation. A design that accepted it would produce two `done` pulses or a result built from the wrong operands.
- **Result hold:** HI/LO sampled in the middle of a run. A design that wrote its partial accumulators into HI/LO during the run would expose them there.
- **Timing:** each `done` is timed against its start, which catches an off-by-one iteration count.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_MUL_S = 2'd0,
    OP_MUL_U = 2'd1,
    OP_DIV_S = 2'd2,
    OP_DIV_U = 2'd3
  } mdOp_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands, magnitudes and sign flags
    logic step;    // one shift-add or shift-subtract iteration
    logic commit;  // sign correction and HI/LO write
  } mdCtl_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startValid,
  output mdCtl_t ctl,
  output logic   busy,
  output logic   done
);

  localparam int CW = $clog2(W);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_e;

  state_e        state;
  logic [CW-1:0] iterCnt;
  logic          lastIter;

  assign lastIter = (iterCnt == CW'(W - 1));

  always_comb begin
    ctl        = '0;
    ctl.load   = (state == S_IDLE) && startValid;
    ctl.step   = (state == S_RUN);
    ctl.commit = (state == S_FIX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= ctl.commit;
      unique case (state)
        S_IDLE: if (startValid) begin
          state   <= S_RUN;
          iterCnt <= '0;
        end
        S_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (lastIter) state <= S_FIX;
        end
        S_FIX:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.step, ctl.commit}));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdCtl_t       ctl,
  input  logic [1:0]   startOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hiReg,
  output logic [W-1:0] loReg
);

  localparam int DW = 2 * W;

  // working state
  logic [W-1:0] accHi, accLo, opMag;
  logic         isDiv, negRes, negRem, divZero;

  // operand preparation at load
  logic         inSigned, aNeg, bNeg;
  logic [W-1:0] aMag, bMag;

  always_comb begin
    inSigned = (startOp == OP_MUL_S) || (startOp == OP_DIV_S);
    aNeg     = inSigned && opA[W-1];
    bNeg     = inSigned && opB[W-1];
    aMag     = aNeg ? (~opA + 1'b1) : opA;
    bMag     = bNeg ? (~opB + 1'b1) : opB;
  end

  // one iteration of each algorithm
  logic [W:0]   mulSum, mulAddend;
  logic [W:0]   divShift;
  logic         divTake;

  always_comb begin
    mulAddend = accLo[0] ? {1'b0, opMag} : '0;
    mulSum    = {1'b0, accHi} + mulAddend;
    divShift  = {accHi, accLo[W-1]};
    divTake   = (divShift >= {1'b0, opMag});
  end

  // sign correction
  logic [DW-1:0] prodMag, prodFix;
  logic [W-1:0]  quoFix, remFix;

  always_comb begin
    prodMag = {accHi, accLo};
    prodFix = negRes ? (~prodMag + 1'b1) : prodMag;
    if (divZero)     quoFix = '1;
    else if (negRes) quoFix = ~accLo + 1'b1;
    else             quoFix = accLo;
    remFix  = negRem ? (~accHi + 1'b1) : accHi;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accHi   <= '0;
      accLo   <= '0;
      opMag   <= '0;
      isDiv   <= 1'b0;
      negRes  <= 1'b0;
      negRem  <= 1'b0;
      divZero <= 1'b0;
      hiReg   <= '0;
      loReg   <= '0;
    end else begin
      if (ctl.load) begin
        accHi   <= '0;
        accLo   <= aMag;
        opMag   <= bMag;
        isDiv   <= startOp[1];
        negRes  <= aNeg ^ bNeg;
        negRem  <= aNeg;
        divZero <= (opB == '0);
      end else if (ctl.step) begin
        if (isDiv) begin
          accHi <= divTake ? W'(divShift - {1'b0, opMag}) : divShift[W-1:0];
          accLo <= {accLo[W-2:0], divTake};
        end else begin
          accHi <= mulSum[W:1];
          accLo <= {mulSum[0], accLo[W-1:1]};
        end
      end
      if (ctl.commit) begin
        if (isDiv) begin
          hiReg <= remFix;
          loReg <= quoFix;
        end else begin
          hiReg <= prodFix[DW-1:W];
          loReg <= prodFix[W-1:0];
        end
      end
    end
  end

  // R7
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> $stable(opMag) && $stable(isDiv));

  // R3
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && isDiv && !divZero) |=> (accHi < opMag));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic [1:0]   startOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hiOut,
  output logic [W-1:0] loOut
);

  mdCtl_t ctl;

  muldiv_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startValid(startValid),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  muldiv_dp #(.W(W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .startOp(startOp),
    .opA    (opA),
    .opB    (opB),
    .hiReg  (hiOut),
    .loReg  (loOut)
  );

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (done || ($stable(hiOut) && $stable(loOut))));

endmodule

// File: tb/sim_muldiv_unit.sv
module sim_muldiv_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [1:0]  startOp = 2'd0;
  logic [31:0] opA = '0, opB = '0;
  logic        busy, done;
  logic [31:0] hiOut, loOut;

  always #4 clk = ~clk;  // 125 MHz

  muldiv_unit u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .hiOut(hiOut), .loOut(loOut)
  );

  typedef struct {
    logic [31:0] hi;
    logic [31:0] lo;
    int          issueCyc;
    string       tag;
  } expItem_t;

  expItem_t sbQ[$];
  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // expected-value model taken from the requirements
  function automatic void model(input logic [1:0] op, input logic [31:0] a,
                                input logic [31:0] b,
                                output logic [31:0] hi, output logic [31:0] lo);
    logic signed [63:0] sa, sb, sp, sq, sr;
    logic [63:0] up;
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    case (op)
      2'd0: begin sp = sa * sb; hi = sp[63:32]; lo = sp[31:0]; end
      2'd1: begin up = {32'd0, a} * {32'd0, b}; hi = up[63:32]; lo = up[31:0]; end
      2'd2: begin
        if (b == 0) begin hi = a; lo = '1; end
        else begin sq = sa / sb; sr = sa % sb; hi = sr[31:0]; lo = sq[31:0]; end
      end
      default: begin
        if (b == 0) begin hi = a; lo = '1; end
        else begin hi = a % b; lo = a / b; end
      end
    endcase
  endfunction

  // driver: waits for idle, issues one start, pushes expected item
  task automatic issue(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    expItem_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    model(op, a, b, it.hi, it.lo);
    it.issueCyc = cyc;
    it.tag = tag;
    sbQ.push_back(it);
    startValid = 1'b1; startOp = op; opA = a; opB = b;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  // monitor: compares each done against the queue head
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbQ.size() == 0) begin
        check(1'b0, "R7 unexpected done", 64'd1, 64'd0);
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        check(hiOut == it.hi, {it.tag, " HI"}, {32'd0, hiOut}, {32'd0, it.hi});
        check(loOut == it.lo, {it.tag, " LO"}, {32'd0, loOut}, {32'd0, it.lo});
        check(cyc - it.issueCyc == 34, "R6 done latency",
              64'(cyc - it.issueCyc), 64'd34);
      end
    end
  end

  task automatic drain();
    @(negedge clk);
    while (busy || sbQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(busy == 0 && done == 0, "R9 busy/done", {busy, done}, 64'd0);
    check(hiOut == 0 && loOut == 0, "R9 HI/LO", {hiOut, loOut}, 64'd0);

    // R1 unsigned multiply
    issue(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 mulu max");
    issue(2'd1, 32'h1234_5678, 32'h9ABC_DEF0, "R1 mulu mix");
    issue(2'd1, 32'd0, 32'hDEAD_BEEF, "R1 mulu zero");
    // R2 signed multiply
    issue(2'd0, 32'hFFFF_FFFF, 32'd7, "R2 muls neg*pos");
    issue(2'd0, 32'h8000_0000, 32'h8000_0000, "R2 muls minint^2");
    issue(2'd0, 32'hFFFF_FFF9, 32'hFFFF_FFFD, "R2 muls neg*neg");
    issue(2'd0, 32'h7FFF_FFFF, 32'h8000_0000, "R2 muls max*min");
    // R3 unsigned divide
    issue(2'd3, 32'd74, 32'd8, "R3 divu small");
    issue(2'd3, 32'hFFFF_FFFF, 32'd3, "R3 divu big");
    issue(2'd3, 32'd5, 32'hFFFF_FFFF, "R3 divu a<b");
    // R4 signed divide
    issue(2'd2, 32'hFFFF_FFF9, 32'd2, "R4 divs -7/2");
    issue(2'd2, 32'd7, 32'hFFFF_FFFE, "R4 divs 7/-2");
    issue(2'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R4 divs -7/-2");
    issue(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R4 divs overflow");
    // R5 divide by zero
    issue(2'd3, 32'hCAFE_F00D, 32'd0, "R5 divu by zero");
    issue(2'd2, 32'h8000_0005, 32'd0, "R5 divs by zero");
    drain();

    // R8 hold: previous result visible mid-run
    issue(2'd1, 32'd3, 32'd5, "R8 setup");
    drain();
    issue(2'd3, 32'd100, 32'd7, "R8 next");
    repeat (10) @(negedge clk);
    check(busy == 1'b1, "R6 busy mid-run", {63'd0, busy}, 64'd1);
    check(hiOut == 0 && loOut == 15, "R8 HI/LO held", {hiOut, loOut}, {32'd0, 32'd15});

    // R7 start while busy is ignored
    startValid = 1'b1; startOp = 2'd0; opA = 32'h1111_1111; opB = 32'h2222_2222;
    @(negedge clk);
    startValid = 1'b0;
    drain();
    repeat (40) @(negedge clk);
    check(busy == 1'b0, "R7 idle after ignored start", {63'd0, busy}, 64'd0);
    check(hiOut == 2 && loOut == 14, "R7 result kept", {hiOut, loOut}, {32'd2, 32'd14});

    finishRun();
  end

endmodule